// File: doc/BRIEF.md
# Grouped Priority Channel Arbiter

This block picks which channel of a multi-channel transfer engine runs next. Channels are arranged in groups. Each group carries a group priority and each channel carries a priority that only has meaning among the channels of its own group. Arbitration happens in two stages. The first stage picks the highest-priority group that has any pending request. The second stage picks the highest-priority requesting channel inside that group. A request comes from software or from a peripheral's hardware request line.

The engine raises an idle strobe when it can accept work. On a cycle with the strobe high and at least one request pending, the arbiter evaluates once and registers its decision. The result is either a grant for one channel, with an acknowledge pulse to the peripheral when that channel presented a hardware request, or an error.

The arbiter also checks the configuration:

- Non-unique group priorities are a global fault, raised by any request.
- Non-unique channel priorities are checked only inside the group that wins.
- A per-channel configuration error line marks a channel that must not run. Its channel number is recorded in the error status.

Error flags are sticky until the clear input. An interrupt is raised when the enable bit of the chosen channel is set.

Top module: `grp_prio_arb`

## Requirements
- R1: Among groups with a pending request (sw_req_i or hw_req_i set on any of its channels), the group with the numerically largest grp_pri_i field wins. A lower group is therefore chosen only when no higher group requests, and a new request in a higher group wins the next arbitration.
- R2: Inside the winning group, the requesting channel with the largest ch_pri_i field (bits [4c+3:4c] for channel c) is chosen. One cycle after a clock edge that sees idle_i high, grant_o is 1 and sel_ch_o equals group*16 + channel, provided no error is detected.
- R3: On equal levels, the lowest-numbered group or channel at the highest requesting level is the chosen one. The interrupt enable bit of that chosen channel decides whether err_irq_o rises.
- R4: Duplicate channel priorities inside a group that is not the winning group raise no error and do not block the grant.
- R5: While any two groups share a group priority, every arbitration with a pending request sets err_grp_o and grants nothing.
- R6: On a group or channel priority error, grant_o stays 0, err_ch_o is 0 and err_vld_o is 0. err_irq_o is set if err_irq_en_i of the chosen channel is 1.
- R7: The error precedence is group priority, then channel priority, then configuration. If ch_err_i of the chosen channel is 1 and there is no priority error, err_cfg_o is set, err_ch_o holds that channel, err_vld_o is 1, and no grant is given. The same error is recorded again on each later arbitration of that channel.
- R8: hw_ack_o has at most one bit set. Bit sel_ch_o is set for exactly the cycle of a grant, and only if that channel's hw_req_i was high at the deciding edge.
- R9: With idle_i low, no decision is made. grant_o and hw_ack_o are 0 and the error outputs hold.
- R10: err_clr_i clears err_grp_o, err_chp_o, err_cfg_o, err_ch_o, err_vld_o and err_irq_o at the next edge. An error detected at the same edge is recorded despite the clear.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_req_i | input | 32 | Software request per channel |
| hw_req_i | input | 32 | Peripheral request per channel |
| ch_pri_i | input | 128 | Channel priority, 4 bits per channel |
| grp_pri_i | input | 2 | Group priority, 1 bit per group |
| ch_err_i | input | 32 | Channel configuration error per channel |
| err_irq_en_i | input | 32 | Error interrupt enable per channel |
| idle_i | input | 1 | Engine idle, arbitration strobe |
| err_clr_i | input | 1 | Clear error status and interrupt |
| grant_o | output | 1 | Grant valid, one cycle |
| sel_ch_o | output | 5 | Granted channel |
| hw_ack_o | output | 32 | Per-channel peripheral acknowledge |
| err_grp_o | output | 1 | Group priority error flag |
| err_chp_o | output | 1 | Channel priority error flag |
| err_cfg_o | output | 1 | Channel configuration error flag |
| err_ch_o | output | 5 | Recorded error channel |
| err_vld_o | output | 1 | Recorded channel is valid |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the arbiter with its defaults: two groups of sixteen channels, 4-bit channel priorities and 1-bit group priorities. With a 1-bit group priority, one register write swaps the order of the two groups or ties them, so pre-emption across groups and the global group error are each one step away. Sixteen channels with 4-bit priorities use every level when the priorities are unique. A single edited priority therefore creates a duplicate, and the bench places that duplicate inside the winning group or inside the losing group to separate the channel error from its absence.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  typedef struct packed {
    logic grp;
    logic chp;
    logic cfg;
  } err_flags_t;
endpackage

// File: rtl/gpa_prio_pick.sv
// Highest-level requester, lowest index on tie; flags any duplicate level.
module gpa_prio_pick #(
  parameter int N  = 16,
  parameter int PW = 4
) (
  input  logic [N*PW-1:0]                  pri_i,
  input  logic [N-1:0]                     req_i,
  output logic [(N > 1 ? $clog2(N) : 1)-1:0] idx_o,
  output logic                             any_o,
  output logic                             dup_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] best;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!any_o || pri_i[i*PW +: PW] > best)) begin
        any_o = 1'b1;
        idx_o = IW'(i);
        best  = pri_i[i*PW +: PW];
      end
    end
  end

  always_comb begin
    dup_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (pri_i[i*PW +: PW] == pri_i[j*PW +: PW]) dup_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpa_err_reg.sv
module gpa_err_reg
  import gpa_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            det_i,
  input  err_flags_t      new_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            irq_en_i,
  input  logic            clr_i,
  output err_flags_t      flags_o,
  output logic [CH_W-1:0] ch_o,
  output logic            vld_o,
  output logic            irq_o
);
  err_flags_t      flags_d;
  logic [CH_W-1:0] ch_d;
  logic            vld_d, irq_d;

  // detection wins over a clear at the same edge
  always_comb begin
    flags_d = (clr_i ? '0 : flags_o) | (det_i ? new_i : '0);
    if (det_i) begin
      ch_d  = new_i.cfg ? ch_i : '0;
      vld_d = new_i.cfg;
    end else begin
      ch_d  = clr_i ? '0 : ch_o;
      vld_d = clr_i ? 1'b0 : vld_o;
    end
    irq_d = (det_i & irq_en_i) | (~clr_i & irq_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      ch_o    <= '0;
      vld_o   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= flags_d;
      ch_o    <= ch_d;
      vld_o   <= vld_d;
      irq_o   <= irq_d;
    end
  end
endmodule

// File: rtl/grp_prio_arb.sv
module grp_prio_arb
  import gpa_pkg::*;
#(
  parameter int N_GRP  = 2,
  parameter int GRP_CH = 16,
  parameter int PRI_W  = 4,
  parameter int GPRI_W = 1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [N_GRP*GRP_CH-1:0]               sw_req_i,
  input  logic [N_GRP*GRP_CH-1:0]               hw_req_i,
  input  logic [N_GRP*GRP_CH*PRI_W-1:0]         ch_pri_i,
  input  logic [N_GRP*GPRI_W-1:0]               grp_pri_i,
  input  logic [N_GRP*GRP_CH-1:0]               ch_err_i,
  input  logic [N_GRP*GRP_CH-1:0]               err_irq_en_i,
  input  logic                                  idle_i,
  input  logic                                  err_clr_i,
  output logic                                  grant_o,
  output logic [$clog2(N_GRP*GRP_CH)-1:0]       sel_ch_o,
  output logic [N_GRP*GRP_CH-1:0]               hw_ack_o,
  output logic                                  err_grp_o,
  output logic                                  err_chp_o,
  output logic                                  err_cfg_o,
  output logic [$clog2(N_GRP*GRP_CH)-1:0]       err_ch_o,
  output logic                                  err_vld_o,
  output logic                                  err_irq_o
);
  localparam int N_CH = N_GRP * GRP_CH;
  localparam int CH_W = $clog2(N_CH);
  localparam int GI_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam int CI_W = (GRP_CH > 1) ? $clog2(GRP_CH) : 1;

  logic [N_CH-1:0]  req;
  logic [N_GRP-1:0] grp_any;
  logic [CI_W-1:0]  ch_idx [N_GRP];
  logic [N_GRP-1:0] ch_dup;
  logic [N_GRP-1:0] ch_any;

  assign req = sw_req_i | hw_req_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_any[g] = |req[g*GRP_CH +: GRP_CH];
    gpa_prio_pick #(.N(GRP_CH), .PW(PRI_W)) u_ch_pick (
      .pri_i (ch_pri_i[g*GRP_CH*PRI_W +: GRP_CH*PRI_W]),
      .req_i (req[g*GRP_CH +: GRP_CH]),
      .idx_o (ch_idx[g]),
      .any_o (ch_any[g]),
      .dup_o (ch_dup[g])
    );
  end

  logic [GI_W-1:0] grp_idx;
  logic            grp_found, grp_dup;

  gpa_prio_pick #(.N(N_GRP), .PW(GPRI_W)) u_grp_pick (
    .pri_i (grp_pri_i),
    .req_i (grp_any),
    .idx_o (grp_idx),
    .any_o (grp_found),
    .dup_o (grp_dup)
  );

  logic [CH_W-1:0] sel;
  logic            win_dup, decide, ok;
  err_flags_t      new_err;
  logic [N_CH-1:0] ack_d;

  assign sel     = CH_W'(grp_idx) * CH_W'(GRP_CH) + CH_W'(ch_idx[grp_idx]);
  assign win_dup = ch_dup[grp_idx];
  assign decide  = idle_i & grp_found & ch_any[grp_idx];

  always_comb begin
    new_err.grp = grp_dup;
    new_err.chp = ~grp_dup & win_dup;
    new_err.cfg = ~grp_dup & ~win_dup & ch_err_i[sel];
    ok          = ~(new_err.grp | new_err.chp | new_err.cfg);
    ack_d       = '0;
    ack_d[sel]  = hw_req_i[sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o  <= 1'b0;
      sel_ch_o <= '0;
      hw_ack_o <= '0;
    end else begin
      grant_o  <= decide & ok;
      hw_ack_o <= (decide & ok) ? ack_d : '0;
      if (decide) sel_ch_o <= sel;
    end
  end

  err_flags_t err_q;

  gpa_err_reg #(.CH_W(CH_W)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .det_i    (decide & ~ok),
    .new_i    (new_err),
    .ch_i     (sel),
    .irq_en_i (err_irq_en_i[sel]),
    .clr_i    (err_clr_i),
    .flags_o  (err_q),
    .ch_o     (err_ch_o),
    .vld_o    (err_vld_o),
    .irq_o    (err_irq_o)
  );

  assign err_grp_o = err_q.grp;
  assign err_chp_o = err_q.chp;
  assign err_cfg_o = err_q.cfg;
endmodule

// File: rtl/grp_prio_arb_chk.sv
module grp_prio_arb_chk #(
  parameter int N_CH = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    idle_i,
  input logic                    err_clr_i,
  input logic                    grant_o,
  input logic [N_CH-1:0]         hw_ack_o,
  input logic                    err_grp_o,
  input logic                    err_chp_o,
  input logic                    err_cfg_o,
  input logic [$clog2(N_CH)-1:0] err_ch_o,
  input logic                    err_vld_o,
  input logic                    err_irq_o
);
  a_r2_grant_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(idle_i));

  a_r8_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hw_ack_o));

  a_r8_ack_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_ack_o) |-> grant_o);

  a_r6_pri_err_no_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(err_grp_o) || $rose(err_chp_o)) |-> (err_ch_o == '0 && !err_vld_o));

  a_r6_irq_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_irq_o) |-> !grant_o);

  a_r7_cfg_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_cfg_o) |-> err_vld_o);

  a_r9_hold_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(idle_i) && !$past(err_clr_i)) |->
      (!grant_o && $stable(err_grp_o) && $stable(err_chp_o) && $stable(err_cfg_o)
       && $stable(err_irq_o)));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_clr_i) && !$past(idle_i)) |->
      (!err_grp_o && !err_chp_o && !err_cfg_o && !err_vld_o && !err_irq_o));
endmodule

bind grp_prio_arb grp_prio_arb_chk #(.N_CH(N_GRP*GRP_CH)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idle_i    (idle_i),
  .err_clr_i (err_clr_i),
  .grant_o   (grant_o),
  .hw_ack_o  (hw_ack_o),
  .err_grp_o (err_grp_o),
  .err_chp_o (err_chp_o),
  .err_cfg_o (err_cfg_o),
  .err_ch_o  (err_ch_o),
  .err_vld_o (err_vld_o),
  .err_irq_o (err_irq_o)
);

// File: tb/test_grp_prio_arb.sv
`timescale 1ns/1ps
module test_grp_prio_arb;
  localparam int NG = 2, GC = 16, PW = 4, NC = NG*GC;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] sw_req = '0, hw_req = '0, ch_err = '0, irq_en = '1;
  logic [NC*PW-1:0] ch_pri;
  logic [NG-1:0] grp_pri = 2'b10;
  logic idle = 0, clr = 0;
  logic [PW-1:0] cpri [NC];

  logic grant, e_grp, e_chp, e_cfg, e_vld, e_irq;
  logic [4:0] sel, e_ch;
  logic [NC-1:0] ack;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < NC; i++) ch_pri[i*PW +: PW] = cpri[i];

  grp_prio_arb i_grp_prio_arb (
    .clk_i(clk), .rst_ni(rst_n), .sw_req_i(sw_req), .hw_req_i(hw_req),
    .ch_pri_i(ch_pri), .grp_pri_i(grp_pri), .ch_err_i(ch_err),
    .err_irq_en_i(irq_en), .idle_i(idle), .err_clr_i(clr),
    .grant_o(grant), .sel_ch_o(sel), .hw_ack_o(ack), .err_grp_o(e_grp),
    .err_chp_o(e_chp), .err_cfg_o(e_cfg), .err_ch_o(e_ch),
    .err_vld_o(e_vld), .err_irq_o(e_irq));

  typedef struct {
    int due; string rq;
    logic g; logic [4:0] s; logic [NC-1:0] a;
    logic [2:0] f; logic [4:0] c; logic v; logic i;
  } item_t;
  item_t q[$];

  int cyc = 0, n_chk = 0, n_fail = 0;
  logic [2:0] m_f = '0; logic [4:0] m_c = '0; logic m_v = 0, m_i = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(string rq, logic id, logic cl);
    item_t it;
    bit any, gf, gdup, cf, cdup;
    int gb, cb, s;
    idle = id; clr = cl;
    it.due = cyc + 1; it.rq = rq; it.g = 0; it.s = 0; it.a = '0;
    any = |(sw_req | hw_req);
    gf = 0; gb = 0; gdup = 0; cf = 0; cb = 0; cdup = 0; s = 0;
    for (int g = 0; g < NG; g++) begin
      if (|((sw_req | hw_req) >> (g*GC)) & ((g == NG-1) || |(((sw_req | hw_req) >> (g*GC)) & {GC{1'b1}})))
        if (|(((sw_req | hw_req) >> (g*GC)) & {GC{1'b1}}) && (!gf || grp_pri[g] > grp_pri[gb])) begin
          gf = 1; gb = g;
        end
      for (int h = g + 1; h < NG; h++) if (grp_pri[g] == grp_pri[h]) gdup = 1;
    end
    for (int c = 0; c < GC; c++) begin
      if ((sw_req[gb*GC+c] | hw_req[gb*GC+c]) && (!cf || cpri[gb*GC+c] > cpri[gb*GC+cb])) begin
        cf = 1; cb = c;
      end
      for (int d = c + 1; d < GC; d++) if (cpri[gb*GC+c] == cpri[gb*GC+d]) cdup = 1;
    end
    s = gb*GC + cb;
    if (cl) begin m_f = '0; m_c = '0; m_v = 0; m_i = 0; end
    if (id && any) begin
      if (gdup || cdup || ch_err[s]) begin
        m_f |= gdup ? 3'b100 : cdup ? 3'b010 : 3'b001;
        m_c = (!gdup && !cdup) ? 5'(s) : 5'd0;
        m_v = !gdup && !cdup;
        if (irq_en[s]) m_i = 1;
      end else begin
        it.g = 1; it.s = 5'(s);
        it.a = hw_req[s] ? (NC'(1) << s) : '0;
      end
    end
    it.f = m_f; it.c = m_c; it.v = m_v; it.i = m_i;
    q.push_back(it);
    @(negedge clk);
    idle = 0; clr = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      chk(it.rq, "grant", 64'(grant), 64'(it.g));
      if (it.g) chk(it.rq, "sel", 64'(sel), 64'(it.s));
      chk(it.rq, "ack", 64'(ack), 64'(it.a));
      chk(it.rq, "flags", 64'({e_grp, e_chp, e_cfg}), 64'(it.f));
      chk(it.rq, "err_ch/vld", 64'({e_ch, e_vld}), 64'({it.c, it.v}));
      chk(it.rq, "irq", 64'(e_irq), 64'(it.i));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < NC; i++) cpri[i] = PW'(i % GC);
    repeat (3) @(negedge clk);
    chk("R11", "reset", 64'({grant, ack, e_grp, e_chp, e_cfg, e_ch, e_vld, e_irq}), 64'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R11", "after reset", 64'({grant, ack, e_grp, e_chp, e_cfg, e_irq}), 64'(0));

    sw_req = '0; sw_req[3] = 1; sw_req[20] = 1; step("R1", 1, 0);
    sw_req = '0; sw_req[17] = 1; sw_req[25] = 1; step("R2", 1, 0);
    sw_req = '0; sw_req[2] = 1; sw_req[9] = 1;   step("R1", 1, 0);
    sw_req[16] = 1;                               step("R1", 1, 0);
    sw_req = '0; hw_req[9] = 1;                   step("R8", 1, 0);
    hw_req = '0; sw_req[9] = 1;                   step("R8", 1, 0);
    sw_req[30] = 1;                               step("R9", 0, 0);

    cpri[5] = 4'd9;
    sw_req = '0; sw_req[18] = 1;                  step("R4", 1, 0);
    sw_req = '0; sw_req[5] = 1; sw_req[9] = 1;
    irq_en = '0; irq_en[5] = 1;                   step("R6", 1, 0);
    step("R10", 0, 1);
    irq_en = '0; irq_en[9] = 1;                   step("R3", 1, 0);
    step("R10", 0, 1);
    irq_en = '1; cpri[5] = 4'd5;

    grp_pri = 2'b00;
    sw_req = '0; sw_req[3] = 1;                   step("R5", 1, 0);
    step("R9", 0, 0);
    step("R10", 0, 1);
    sw_req[30] = 1; irq_en = '0; irq_en[3] = 1;   step("R3", 1, 0);
    step("R10", 0, 1);
    irq_en = '0; irq_en[30] = 1;                  step("R3", 1, 0);
    irq_en = '1;                                  step("R10", 1, 1);
    step("R10", 0, 1);

    grp_pri = 2'b10;
    sw_req = '0; sw_req[20] = 1; ch_err[20] = 1;  step("R7", 1, 0);
    step("R10", 0, 1);
    step("R7", 1, 0);
    ch_err = '0; ch_err[2] = 1; sw_req[2] = 1;    step("R7", 1, 0);
    step("R10", 0, 1);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule